// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset indications into one internal reset for the rest of the chip. The indications are a supply-below-threshold flag, a reset-pin level, a one-cycle watchdog timeout strobe and a brown-out comparator output. Once the last active source goes away, the reset is held for a start-up delay. That delay has two phases: first a real-time phase counted in watchdog-oscillator cycles, then a phase counted in system-clock cycles. The select inputs choose the length of each phase, and some settings skip the real-time phase entirely. A wake from sleep uses only the clock-count phase and raises a separate hold output; it does not assert reset.

All logic runs on one fast clock `clk`. The two slower time bases arrive as one-cycle enables: `wdo_tick` for the watchdog oscillator and `clk_tick` for the system clock. A brown-out indication has to persist for a qualification time, counted in watchdog-oscillator cycles, before it is accepted. A cause register records which sources have fired. Software reads it and clears bits by writing zeros.

The supply indication `por_low` acts as an asynchronous reset for every register in the block. All pins are plain control and status pins; the block has no streaming interface, so there is no back-pressure.

Top module: `rst_sequencer`

## Requirements
- R1: `rst_out` is 1 in the same cycle that `por_low` or `pin_low` is 1, with no clock edge in between.
- R2: After the last cycle in which a source is active, `rst_out` stays 1 for one clock plus the real-time length counted in `wdo_tick` pulses, plus the clock-count length counted in `clk_tick` pulses. It then falls to 0.
- R3: `cksel[3:2]` selects the real-time length. 00 gives no real-time phase. 01 gives 256 ticks when `slow_lvl`=0 and 1024 ticks when `slow_lvl`=1. 10 or 11 gives 4096 ticks when `slow_lvl`=0 and 16384 ticks when `slow_lvl`=1.
- R4: `cksel[1:0]` selects the clock-count length: 00 gives 6, 01 gives 1024, 10 gives 16384 and 11 gives 32768 `clk_tick` pulses.
- R5: A one-cycle `wdt_pulse` asserts `rst_out`. The delay is counted from the cycle after the pulse.
- R6: A `wake_req` pulse while the block is running raises `wake_hold` for the clock-count length only. `rst_out` stays 0 throughout.
- R7: A brown-out is accepted only when `bod_en`=1 and `bod_low` has stayed 1 for BOD_QUAL (default 8) `wdo_tick` pulses. A shorter episode, or any episode with `bod_en`=0, leaves `rst_out` and `stat[2]` unchanged.
- R8: The fields of `stat` are: bit 3 watchdog cause, bit 2 brown-out cause, bit 1 pin cause, bit 0 power-on cause. Bits 7..4 always read 0.
- R9: `por_low` forces `stat` to 8'h01. Every other source ORs in its own bit, one cycle after it is seen active.
- R10: A cycle with `stat_wr`=1 ANDs the four cause bits with `stat_wdata[3:0]`. A source that is active in the same cycle still sets its bit.
- R11: A source that becomes active again during a delay in progress restarts the whole delay from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| por_low | input | 1 | Supply below power-on level; asynchronous reset of the block |
| pin_low | input | 1 | Reset pin is low |
| wdt_pulse | input | 1 | One-cycle watchdog timeout strobe |
| bod_low | input | 1 | Brown-out comparator: supply below trigger |
| bod_en | input | 1 | Brown-out detection enabled |
| wdo_tick | input | 1 | Watchdog-oscillator cycle enable |
| clk_tick | input | 1 | System-clock cycle enable |
| cksel | input | 4 | Delay select code |
| slow_lvl | input | 1 | Picks the longer real-time lengths |
| wake_req | input | 1 | Wake-from-sleep request strobe |
| stat_wr | input | 1 | Cause-register write strobe |
| stat_wdata | input | 8 | Cause-register write data (zeros clear) |
| rst_out | output | 1 | Internal reset, active high |
| wake_hold | output | 1 | Core held while the wake delay runs |
| stat | output | 8 | Reset-cause register |

## Verification
A wrong phase or counter value appears on `rst_out` as a release that comes early or late. The error shows up at the end of the current delay at the latest, and in the cycle after a source drops if the phase machine takes the wrong branch. A wrong brown-out qualification count shows up as a reset that starts one tick early or late, or as a missing `stat[2]`. A corrupted cause bit is visible on `stat` one cycle after the bad write or set. The reference model is compared on every clock, so each such error is reported in the cycle it first becomes visible.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    PH_ARM  = 3'd0,
    PH_RT   = 3'd1,
    PH_CK   = 3'd2,
    PH_RUN  = 3'd3,
    PH_WAKE = 3'd4
  } phase_t;
endpackage

// File: rtl/rs_bod_qual.sv
module rs_bod_qual #(
  parameter int QUAL = 8
) (
  input  logic clk,
  input  logic por_low,
  input  logic bod_low,
  input  logic bod_en,
  input  logic wdo_tick,
  output logic bod_hit
);
  localparam int QW = $clog2(QUAL + 1);
  logic [QW-1:0] cnt;
  logic          low_q;

  assign low_q = bod_low & bod_en;

  // counts slow ticks while brown-out persists, saturates at QUAL
  always_ff @(posedge clk or posedge por_low) begin
    if (por_low)                                 cnt <= '0;
    else if (!low_q)                             cnt <= '0;
    else if (wdo_tick && cnt != QW'(QUAL))       cnt <= cnt + QW'(1);
  end

  assign bod_hit = low_q && (cnt == QW'(QUAL));
endmodule

// File: rtl/rs_len_decode.sv
module rs_len_decode #(
  parameter int CW          = 16,
  parameter int RT_SHORT_LO = 256,
  parameter int RT_SHORT_HI = 1024,
  parameter int RT_LONG_LO  = 4096,
  parameter int RT_LONG_HI  = 16384,
  parameter int CK_0        = 6,
  parameter int CK_1        = 1024,
  parameter int CK_2        = 16384,
  parameter int CK_3        = 32768
) (
  input  logic [3:0]    cksel,
  input  logic          slow_lvl,
  output logic [CW-1:0] rt_len,
  output logic [CW-1:0] ck_len
);
  always_comb begin
    case (cksel[3:2])
      2'b00:   rt_len = '0;
      2'b01:   rt_len = slow_lvl ? CW'(RT_SHORT_HI) : CW'(RT_SHORT_LO);
      default: rt_len = slow_lvl ? CW'(RT_LONG_HI)  : CW'(RT_LONG_LO);
    endcase
    case (cksel[1:0])
      2'b00:   ck_len = CW'(CK_0);
      2'b01:   ck_len = CW'(CK_1);
      2'b10:   ck_len = CW'(CK_2);
      default: ck_len = CW'(CK_3);
    endcase
  end
endmodule

// File: rtl/rs_cause_reg.sv
module rs_cause_reg #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            por_low,
  input  logic [NSRC-1:0] set_vec,
  input  logic            wr,
  input  logic [NSRC-1:0] wmask,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] kept;

  assign kept = wr ? (flags & wmask) : flags;

  // power-on leaves only its own bit; sets win over a clearing write
  always_ff @(posedge clk or posedge por_low) begin
    if (por_low) flags <= NSRC'(1);
    else         flags <= kept | set_vec;
  end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int BOD_QUAL    = 8,
  parameter int RT_SHORT_LO = 256,
  parameter int RT_SHORT_HI = 1024,
  parameter int RT_LONG_LO  = 4096,
  parameter int RT_LONG_HI  = 16384,
  parameter int CK_0        = 6,
  parameter int CK_1        = 1024,
  parameter int CK_2        = 16384,
  parameter int CK_3        = 32768,
  parameter int STAT_W      = 8
) (
  input  logic              clk,
  input  logic              por_low,
  input  logic              pin_low,
  input  logic              wdt_pulse,
  input  logic              bod_low,
  input  logic              bod_en,
  input  logic              wdo_tick,
  input  logic              clk_tick,
  input  logic [3:0]        cksel,
  input  logic              slow_lvl,
  input  logic              wake_req,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              rst_out,
  output logic              wake_hold,
  output logic [STAT_W-1:0] stat
);
  import rstseq_pkg::*;

  localparam int NSRC = 4;
  localparam int MAXL = (RT_LONG_HI > CK_3) ? RT_LONG_HI : CK_3;
  localparam int CW   = $clog2(MAXL + 1);

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   rt_len;
  logic [CW-1:0]   ck_len;
  logic            bod_hit;
  logic            src;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] set_vec;

  rs_bod_qual #(.QUAL(BOD_QUAL)) u_bod (
    .clk(clk), .por_low(por_low), .bod_low(bod_low), .bod_en(bod_en),
    .wdo_tick(wdo_tick), .bod_hit(bod_hit)
  );

  rs_len_decode #(
    .CW(CW), .RT_SHORT_LO(RT_SHORT_LO), .RT_SHORT_HI(RT_SHORT_HI),
    .RT_LONG_LO(RT_LONG_LO), .RT_LONG_HI(RT_LONG_HI),
    .CK_0(CK_0), .CK_1(CK_1), .CK_2(CK_2), .CK_3(CK_3)
  ) u_dec (
    .cksel(cksel), .slow_lvl(slow_lvl), .rt_len(rt_len), .ck_len(ck_len)
  );

  assign set_vec = {wdt_pulse, bod_hit, pin_low, 1'b0};

  rs_cause_reg #(.NSRC(NSRC)) u_cause (
    .clk(clk), .por_low(por_low), .set_vec(set_vec), .wr(stat_wr),
    .wmask(stat_wdata[NSRC-1:0]), .flags(flags)
  );

  assign src = pin_low | bod_hit | wdt_pulse;

  always_ff @(posedge clk or posedge por_low) begin
    if (por_low) begin
      phase <= PH_ARM;
      cnt   <= '0;
    end else if (src) begin
      phase <= PH_ARM;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_ARM: begin
          phase <= (rt_len == '0) ? PH_CK : PH_RT;
          cnt   <= '0;
        end
        PH_RT: if (wdo_tick) begin
          if (cnt == rt_len - CW'(1)) begin
            phase <= PH_CK;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        PH_CK: if (clk_tick) begin
          if (cnt == ck_len - CW'(1)) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        PH_RUN: if (wake_req) begin
          phase <= PH_WAKE;
          cnt   <= '0;
        end
        PH_WAKE: if (clk_tick) begin
          if (cnt == ck_len - CW'(1)) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        default: begin
          phase <= PH_ARM;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign rst_out   = por_low | src | ((phase != PH_RUN) && (phase != PH_WAKE));
  assign wake_hold = (phase == PH_WAKE);
  assign stat      = {{(STAT_W-NSRC){1'b0}}, flags};
endmodule

// File: rtl/rs_chk.sv
module rs_chk (
  input logic       clk,
  input logic       por_low,
  input logic       pin_low,
  input logic       wdt_pulse,
  input logic       wake_req,
  input logic       stat_wr,
  input logic [7:0] stat_wdata,
  input logic       rst_out,
  input logic       wake_hold,
  input logic [7:0] stat
);
  // R1
  pin_reset_now_chk: assert property (@(posedge clk) disable iff (por_low)
    pin_low |-> rst_out);

  // R5
  wdt_holds_chk: assert property (@(posedge clk) disable iff (por_low)
    wdt_pulse |=> rst_out);

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (por_low)
    stat[7:4] == 4'h0);

  // R9
  wdt_flag_chk: assert property (@(posedge clk) disable iff (por_low)
    wdt_pulse |=> stat[3]);

  // R10
  por_flag_clear_chk: assert property (@(posedge clk) disable iff (por_low)
    (stat_wr && !stat_wdata[0]) |=> !stat[0]);

  // R6
  wake_entry_chk: assert property (@(posedge clk) disable iff (por_low)
    $rose(wake_hold) |-> ($past(wake_req) && !$past(rst_out)));

  // R6
  wake_no_reset_chk: assert property (@(posedge clk) disable iff (por_low)
    (wake_hold && !pin_low && !wdt_pulse) |-> !rst_out);
endmodule

bind rst_sequencer rs_chk u_chk (
  .clk(clk), .por_low(por_low), .pin_low(pin_low), .wdt_pulse(wdt_pulse),
  .wake_req(wake_req), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
  .rst_out(rst_out), .wake_hold(wake_hold), .stat(stat)
);

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
  logic       clk = 1'b0;
  logic       por_low = 1'b1;
  logic       pin_low = 1'b0;
  logic       wdt_pulse = 1'b0;
  logic       bod_low = 1'b0;
  logic       bod_en = 1'b0;
  logic       wdo_tick = 1'b0;
  logic       clk_tick = 1'b0;
  logic [3:0] cksel = 4'b0000;
  logic       slow_lvl = 1'b0;
  logic       wake_req = 1'b0;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic       rst_out;
  logic       wake_hold;
  logic [7:0] stat;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int wdo_div = 1;
  bit done = 1'b0;

  localparam int QUAL = 8;

  always #5 clk = ~clk;

  rst_sequencer u0 (
    .clk(clk), .por_low(por_low), .pin_low(pin_low), .wdt_pulse(wdt_pulse),
    .bod_low(bod_low), .bod_en(bod_en), .wdo_tick(wdo_tick),
    .clk_tick(clk_tick), .cksel(cksel), .slow_lvl(slow_lvl),
    .wake_req(wake_req), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .rst_out(rst_out), .wake_hold(wake_hold), .stat(stat)
  );

  function automatic int rt_of(input logic [3:0] s, input logic lv);
    if (s[3:2] == 2'b00) return 0;
    if (s[3:2] == 2'b01) return lv ? 1024 : 256;
    return lv ? 16384 : 4096;
  endfunction

  function automatic int ck_of(input logic [3:0] s);
    case (s[1:0])
      2'b00: return 6;
      2'b01: return 1024;
      2'b10: return 16384;
      default: return 32768;
    endcase
  endfunction

  // reference model: 0 waiting, 1 slow wait, 2 clock wait, 3 running, 4 waking
  int m_mode = 0;
  int m_left = 0;
  int m_bod = 0;
  logic [3:0] m_flags = 4'h1;

  function automatic bit m_bod_on();
    return bod_en && bod_low && (m_bod >= QUAL);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (por_low) begin
      m_mode = 0; m_bod = 0; m_flags = 4'h1;
    end else begin
      bit b, s;
      b = m_bod_on();
      s = pin_low || b || wdt_pulse;
      if (stat_wr) m_flags = m_flags & stat_wdata[3:0];
      if (wdt_pulse) m_flags[3] = 1'b1;
      if (b)         m_flags[2] = 1'b1;
      if (pin_low)   m_flags[1] = 1'b1;
      if (!(bod_en && bod_low)) m_bod = 0;
      else if (wdo_tick && m_bod < QUAL) m_bod++;
      if (s) m_mode = 0;
      else begin
        case (m_mode)
          0: begin
            if (rt_of(cksel, slow_lvl) > 0) begin m_mode = 1; m_left = rt_of(cksel, slow_lvl); end
            else begin m_mode = 2; m_left = ck_of(cksel); end
          end
          1: if (wdo_tick) begin
            m_left--;
            if (m_left == 0) begin m_mode = 2; m_left = ck_of(cksel); end
          end
          2: if (clk_tick) begin m_left--; if (m_left == 0) m_mode = 3; end
          3: if (wake_req) begin m_mode = 4; m_left = ck_of(cksel); end
          4: if (clk_tick) begin m_left--; if (m_left == 0) m_mode = 3; end
          default: m_mode = 0;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      bit er; int ew; int es;
      er = por_low || pin_low || wdt_pulse || m_bod_on() || (m_mode < 3);
      ew = (!por_low && m_mode == 4) ? 1 : 0;
      es = por_low ? 1 : int'(m_flags);
      check(rst_out == er, "R2 rst_out model", int'(rst_out), int'(er));
      check(int'(wake_hold) == ew, "R6 wake_hold model", int'(wake_hold), ew);
      check(int'(stat) == es, "R8 stat model", int'(stat), es);
    end
  end

  // slow tick generator, 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    wdo_tick = (cyc % wdo_div) == 0;
    clk_tick = 1'b1;
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (rst_out && n < 60000) begin step(1); n++; end
  endtask

  initial begin
    int n;
    step(3);
    check(rst_out == 1'b1, "R1 reset during power-on", int'(rst_out), 1);
    check(stat == 8'h01, "R9 power-on cause", int'(stat), 1);
    por_low = 1'b0;
    count_release(n);
    check(n == 1 + 6, "R4 power-on release, 6 clocks", n, 7);

    // pin reset, immediate and flagged
    pin_low = 1'b1; #1;
    check(rst_out == 1'b1, "R1 pin same cycle", int'(rst_out), 1);
    step(3); pin_low = 1'b0;
    check(stat == 8'h03, "R9 pin cause ORs in", int'(stat), 3);
    count_release(n);
    check(n == 7, "R2 pin release", n, 7);

    // write ones keeps, zeros clear
    stat_wr = 1'b1; stat_wdata = 8'hFF; step(1); stat_wr = 1'b0;
    check(stat == 8'h03, "R10 ones keep", int'(stat), 3);
    stat_wr = 1'b1; stat_wdata = 8'h00; step(1); stat_wr = 1'b0;
    check(stat == 8'h00, "R10 zeros clear", int'(stat), 0);

    // watchdog with short slow phase, slow ticks every 2nd cycle
    wdo_div = 2; cksel = 4'b0100; slow_lvl = 1'b0;
    wdt_pulse = 1'b1; stat_wr = 1'b1; stat_wdata = 8'h00;
    step(1); wdt_pulse = 1'b0; stat_wr = 1'b0;
    check(stat == 8'h08, "R10 set beats clear, R8 bit3", int'(stat), 8);
    check(rst_out == 1'b1, "R5 reset after pulse", int'(rst_out), 1);
    count_release(n);
    check(n >= 1 + 2*256 - 1 && n <= 1 + 2*256 + 1 + 6, "R3 slow phase 256 ticks", n, 1 + 512 + 6);
    stat_wr = 1'b1; stat_wdata = 8'h00; step(1); stat_wr = 1'b0;

    // brown-out: short episode ignored, disabled ignored, long accepted
    wdo_div = 1; cksel = 4'b0000;
    bod_en = 1'b1; bod_low = 1'b1; step(5); bod_low = 1'b0; step(2);
    check(rst_out == 1'b0 && stat[2] == 1'b0, "R7 short brown-out ignored", int'(rst_out), 0);
    bod_en = 1'b0; bod_low = 1'b1; step(20); bod_low = 1'b0; step(1);
    check(rst_out == 1'b0 && stat == 8'h00, "R7 disabled brown-out ignored", int'(stat), 0);
    bod_en = 1'b1; bod_low = 1'b1; step(QUAL - 1);
    check(rst_out == 1'b0, "R7 not yet qualified", int'(rst_out), 0);
    step(2);
    check(rst_out == 1'b1, "R7 qualified brown-out resets", int'(rst_out), 1);
    step(1);
    check(stat == 8'h04, "R8 bit2 brown-out cause", int'(stat), 4);
    bod_low = 1'b0;
    count_release(n);
    check(n == 7, "R2 brown-out release", n, 7);

    // restart on new source during the delay
    cksel = 4'b0100;
    pin_low = 1'b1; step(1); pin_low = 1'b0; step(100);
    pin_low = 1'b1; step(1); pin_low = 1'b0;
    count_release(n);
    check(n == 1 + 256 + 6, "R11 delay restarts", n, 263);

    // wake uses clock phase only
    cksel = 4'b0101;
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    n = 1;
    while (wake_hold && n < 5000) begin
      check(rst_out == 1'b0, "R6 no reset while waking", int'(rst_out), 0);
      step(1); n++;
    end
    check(n == 1 + 1024, "R6 wake length", n, 1025);

    // longest settings
    cksel = 4'b1011; slow_lvl = 1'b1;
    pin_low = 1'b1; step(1); pin_low = 1'b0;
    count_release(n);
    check(n == 1 + 16384 + 32768, "R3 R4 longest delay", n, 49153);
    check(stat[7:4] == 4'h0, "R8 upper bits zero", int'(stat[7:4]), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule